// File: doc/BRIEF.md
# Eight-Bit Arithmetic/Logic Unit with Status Flags

This block is the combinational datapath of a small processor. Two operand buses, a 4-bit operation code and a carry input produce an 8-bit result together with four status bits: carry, sign, zero and overflow. The carry and overflow bits come from two particular internal carries of a ripple adder. Carry is the end carry out of the most significant bit. Overflow is the XOR of the carry into that bit and the carry out of it. Subtraction is performed as `A + ~B + 1`, so a carry flag of 1 means that no borrow occurred.

Alongside the combinational flags, a flag register captures all four bits on a rising clock edge whenever `flag_we` is high. Later conditional-branch logic reads that register. Compare and test codes compute a difference and a bitwise AND respectively, and they update the flags in the same way as subtract and AND. They lower `result_we`, however, so the surrounding datapath does not write their value back to a register.

Top module: `alu_status_unit`

## Requirements
- R1: For arithmetic codes (op[3]=0), `c_out` equals the carry out of bit 7 of the internal addition `X + Y + Cin`. For logic-class codes (op[3]=1), `c_out` is 0.
- R2: `s_out` equals bit 7 of the value the operation computes. For codes 7 and 13 this is the value they would produce, even though it is not written back.
- R3: `z_out` is 1 exactly when all 8 bits of that computed value are 0.
- R4: For arithmetic codes, `v_out` is the XOR of the carry into bit 7 and the carry out of bit 7. For logic-class codes, `v_out` is 0.
- R5: The arithmetic codes are defined by the addend tuple (X, Y, Cin) as follows. 0 ADD = (A, B, 0). 1 ADDC = (A, B, carry_in). 2 SUB = (A, ~B, 1). 3 SUBB = (A, ~B, carry_in). 4 INC = (A, 0, 1). 5 DEC = (A, 0xFF, 0). 6 NEG = (0, ~A, 1).
- R6: The logic codes produce the following results. 8 AND gives A&B. 9 OR gives A|B. 10 XOR gives A^B. 11 COM gives ~A. 12 CLR gives 0.
- R7: Code 7 (compare) behaves as SUB and code 13 (test) behaves as AND for `result` and all flags, but both drive `result_we` low. Every other code drives `result_we` high.
- R8: Codes 14 and 15 pass A unchanged to `result` and are logic-class for the flags.
- R9: On a rising clock edge with `flag_we` high, the registered flags take the current `c_out`/`s_out`/`z_out`/`v_out`. With `flag_we` low, they hold their value.
- R10: While `rst_n` is low, all four registered flags are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the flag register |
| rst_n | input | 1 | Active-low asynchronous reset of the flag register |
| a | input | 8 | Operand bus A |
| b | input | 8 | Operand bus B |
| op | input | 4 | Operation code (see R5 to R8) |
| carry_in | input | 1 | Carry input for ADDC and SUBB |
| flag_we | input | 1 | Load enable for the flag register |
| result | output | 8 | Computed value |
| result_we | output | 1 | Low for compare and test codes |
| c_out | output | 1 | Combinational carry flag |
| s_out | output | 1 | Combinational sign flag |
| z_out | output | 1 | Combinational zero flag |
| v_out | output | 1 | Combinational overflow flag |
| flag_c | output | 1 | Registered carry flag |
| flag_s | output | 1 | Registered sign flag |
| flag_z | output | 1 | Registered zero flag |
| flag_v | output | 1 | Registered overflow flag |

## Verification
The assertions check several relations on every cycle, whatever the operands. Carry for ADD is checked against a wide sum. Overflow may not appear on ADD when the operand signs differ. SUB and compare must report zero exactly when the operands match. Logic-class codes must keep carry and overflow low. Compare and test must withhold `result_we`. The flag register must hold or load according to `flag_we`. Exact result and flag values are shown only by the bench's scenarios, together with the reset value of the flag register. These scenarios cover signed wrap at 0x7F/0x80, negation of 0x80 and of 0, decrement of 0, subtract with and without borrow, and the pass-through behaviour of the unused codes.

// File: rtl/alu_status_pkg.sv
package alu_status_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADDC = 4'd1,
    OP_SUB  = 4'd2,
    OP_SUBB = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_NEG  = 4'd6,
    OP_CMP  = 4'd7,
    OP_AND  = 4'd8,
    OP_OR   = 4'd9,
    OP_XOR  = 4'd10,
    OP_COM  = 4'd11,
    OP_CLR  = 4'd12,
    OP_TST  = 4'd13
  } alu_op_e;

  typedef struct packed {
    logic c;
    logic s;
    logic z;
    logic v;
  } alu_flags_t;

  // Arithmetic class is selected by the top bit of the code being clear.
  function automatic logic op_is_arith(input logic [3:0] op);
    return ~op[3];
  endfunction

  // Compare and test produce flags only.
  function automatic logic op_writes_result(input logic [3:0] op);
    return !(op == OP_CMP || op == OP_TST);
  endfunction

endpackage

// File: rtl/alu_operand_sel.sv
module alu_operand_sel
  import alu_status_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         carry_in,
  output logic [W-1:0] x,
  output logic [W-1:0] y,
  output logic         cin
);

  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};
  localparam logic [W-1:0] ALL_ZERO = '0;

  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    unique case (op)
      OP_ADD:          begin y = b;        cin = 1'b0;     end
      OP_ADDC:         begin y = b;        cin = carry_in; end
      OP_SUB, OP_CMP:  begin y = ~b;       cin = 1'b1;     end
      OP_SUBB:         begin y = ~b;       cin = carry_in; end
      OP_INC:          begin y = ALL_ZERO; cin = 1'b1;     end
      OP_DEC:          begin y = ALL_ONES; cin = 1'b0;     end
      OP_NEG:          begin x = ALL_ZERO; y = ~a; cin = 1'b1; end
      default:         begin x = a;        y = b;  cin = 1'b0; end
    endcase
  end

endmodule

// File: rtl/alu_ripple_adder.sv
module alu_ripple_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] x,
  input  logic [W-1:0] y,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         carry_into_msb,
  output logic         carry_end
);

  logic [W:0] chain;

  assign chain[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_bit
      assign sum[i]     = x[i] ^ y[i] ^ chain[i];
      assign chain[i+1] = (x[i] & y[i]) | (chain[i] & (x[i] ^ y[i]));
    end
  endgenerate

  assign carry_into_msb = chain[W-1];
  assign carry_end      = chain[W];

endmodule

// File: rtl/alu_logic_unit.sv
module alu_logic_unit
  import alu_status_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y
);

  always_comb begin
    unique case (op)
      OP_AND, OP_TST: y = a & b;
      OP_OR:          y = a | b;
      OP_XOR:         y = a ^ b;
      OP_COM:         y = ~a;
      OP_CLR:         y = '0;
      default:        y = a;
    endcase
  end

endmodule

// File: rtl/alu_flag_reg.sv
module alu_flag_reg
  import alu_status_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  alu_flags_t d,
  output alu_flags_t q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  // R9: hold when the enable is low
  p_flags_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

  // R9: load the presented flags when enabled
  p_flags_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> q == $past(d));

endmodule

// File: rtl/alu_status_unit.sv
module alu_status_unit
  import alu_status_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   op,
  input  logic         carry_in,
  input  logic         flag_we,
  output logic [W-1:0] result,
  output logic         result_we,
  output logic         c_out,
  output logic         s_out,
  output logic         z_out,
  output logic         v_out,
  output logic         flag_c,
  output logic         flag_s,
  output logic         flag_z,
  output logic         flag_v
);

  logic [W-1:0] add_x, add_y, add_sum, logic_y;
  logic         add_cin, carry_into_msb, carry_end, arith;
  alu_flags_t   flags_now, flags_q;

  alu_operand_sel #(.W(W)) u_sel (
    .op(op), .a(a), .b(b), .carry_in(carry_in),
    .x(add_x), .y(add_y), .cin(add_cin)
  );

  alu_ripple_adder #(.W(W)) u_add (
    .x(add_x), .y(add_y), .cin(add_cin),
    .sum(add_sum), .carry_into_msb(carry_into_msb), .carry_end(carry_end)
  );

  alu_logic_unit #(.W(W)) u_logic (
    .op(op), .a(a), .b(b), .y(logic_y)
  );

  assign arith     = op_is_arith(op);
  assign result    = arith ? add_sum : logic_y;
  assign result_we = op_writes_result(op);

  assign flags_now.c = arith & carry_end;
  assign flags_now.v = arith & (carry_into_msb ^ carry_end);
  assign flags_now.s = result[W-1];
  assign flags_now.z = ~|result;

  assign c_out = flags_now.c;
  assign s_out = flags_now.s;
  assign z_out = flags_now.z;
  assign v_out = flags_now.v;

  alu_flag_reg u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we), .d(flags_now), .q(flags_q)
  );

  assign flag_c = flags_q.c;
  assign flag_s = flags_q.s;
  assign flag_z = flags_q.z;
  assign flag_v = flags_q.v;

  // Independent wide sums used only by the checks below.
  logic [W:0]        chk_add_wide;
  logic signed [W:0] chk_add_signed;
  assign chk_add_wide   = {1'b0, a} + {1'b0, b};
  assign chk_add_signed = $signed({a[W-1], a}) + $signed({b[W-1], b});

  // R1: ADD carry equals the top bit of the widened sum
  p_add_carry_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD) |-> c_out == chk_add_wide[W]);

  // R2: without overflow, ADD sign matches the true signed sum
  p_add_sign_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && !v_out) |-> s_out == chk_add_signed[W]);

  // R3: subtraction and compare give zero exactly for equal operands
  p_sub_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_SUB || op == OP_CMP) |-> z_out == (a == b));

  // R4: operands of differing sign can never overflow on ADD
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_ADD && a[W-1] != b[W-1]) |-> !v_out);

  // R6 / R8: logic class keeps carry and overflow clear
  p_logic_cv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    op[3] |-> (!c_out && !v_out));

  // R6: clear yields zero and raises the zero flag
  p_clear_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CLR) |-> (result == '0 && z_out));

  // R7: compare and test never request a write-back
  p_flags_only_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op == OP_CMP || op == OP_TST) |-> !result_we);

endmodule

// File: tb/alu_status_unit_test.sv
module alu_status_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] a = '0, b = '0;
  logic [3:0] op = '0;
  logic       carry_in = 1'b0, flag_we = 1'b0;
  logic [7:0] result;
  logic       result_we, c_out, s_out, z_out, v_out;
  logic       flag_c, flag_s, flag_z, flag_v;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  alu_status_unit uut (
    .clk(clk), .rst_n(rst_n), .a(a), .b(b), .op(op), .carry_in(carry_in),
    .flag_we(flag_we), .result(result), .result_we(result_we),
    .c_out(c_out), .s_out(s_out), .z_out(z_out), .v_out(v_out),
    .flag_c(flag_c), .flag_s(flag_s), .flag_z(flag_z), .flag_v(flag_v)
  );

  // {op, a, b, carry_in, expected result, expected C S Z V}
  localparam int NV = 26;
  localparam logic [32:0] VEC [0:NV-1] = '{
    {4'd0,  8'h3C, 8'h14, 1'b0, 8'h50, 4'b0000}, // R5 ADD plain
    {4'd0,  8'h7F, 8'h01, 1'b0, 8'h80, 4'b0101}, // R4 R2 signed wrap
    {4'd0,  8'hFF, 8'h01, 1'b0, 8'h00, 4'b1010}, // R1 R3 end carry
    {4'd1,  8'h10, 8'h20, 1'b1, 8'h31, 4'b0000}, // R5 ADDC
    {4'd1,  8'hFF, 8'h00, 1'b1, 8'h00, 4'b1010}, // R1 ADDC carry
    {4'd2,  8'h05, 8'h03, 1'b0, 8'h02, 4'b1000}, // R1 no borrow
    {4'd2,  8'h03, 8'h05, 1'b0, 8'hFE, 4'b0100}, // R1 borrow
    {4'd2,  8'h80, 8'h01, 1'b0, 8'h7F, 4'b1001}, // R4 SUB overflow
    {4'd3,  8'h10, 8'h01, 1'b0, 8'h0E, 4'b1000}, // R5 SUBB borrow in
    {4'd3,  8'h10, 8'h01, 1'b1, 8'h0F, 4'b1000}, // R5 SUBB no borrow in
    {4'd4,  8'h7F, 8'h00, 1'b0, 8'h80, 4'b0101}, // R5 INC wrap
    {4'd5,  8'h00, 8'h00, 1'b0, 8'hFF, 4'b0100}, // R5 DEC of zero
    {4'd5,  8'h01, 8'h00, 1'b0, 8'h00, 4'b1010}, // R5 DEC to zero
    {4'd6,  8'h01, 8'h00, 1'b0, 8'hFF, 4'b0100}, // R5 NEG
    {4'd6,  8'h80, 8'h00, 1'b0, 8'h80, 4'b0101}, // R4 NEG of 0x80
    {4'd6,  8'h00, 8'h00, 1'b0, 8'h00, 4'b1010}, // R1 NEG of zero
    {4'd7,  8'h42, 8'h42, 1'b0, 8'h00, 4'b1010}, // R7 CMP equal
    {4'd8,  8'hF0, 8'h3C, 1'b1, 8'h30, 4'b0000}, // R6 AND
    {4'd9,  8'h81, 8'h02, 1'b0, 8'h83, 4'b0100}, // R6 OR
    {4'd10, 8'hAA, 8'hAA, 1'b0, 8'h00, 4'b0010}, // R6 XOR
    {4'd11, 8'h0F, 8'h55, 1'b0, 8'hF0, 4'b0100}, // R6 COM
    {4'd12, 8'h9C, 8'h77, 1'b1, 8'h00, 4'b0010}, // R6 CLR
    {4'd13, 8'h80, 8'h80, 1'b0, 8'h80, 4'b0100}, // R7 TST
    {4'd13, 8'h0F, 8'hF0, 1'b1, 8'h00, 4'b0010}, // R7 TST zero
    {4'd14, 8'h00, 8'hFF, 1'b1, 8'h00, 4'b0010}, // R8 pass A
    {4'd15, 8'h9A, 8'h11, 1'b1, 8'h9A, 4'b0100}  // R8 pass A
  };

  task automatic check(input string req, input logic [12:0] act, input logic [12:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  endtask

  initial begin
    #2_000_000;
    n_fails++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    // R10: reset state
    repeat (2) @(negedge clk);
    check("R10 reset", {9'd0, flag_c, flag_s, flag_z, flag_v}, 13'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table of vectors: combinational result, result_we and flags (R1-R8 tagged per row)
    for (int i = 0; i < NV; i++) begin
      {op, a, b, carry_in} = VEC[i][32:12];
      #2;
      check($sformatf("vector %0d", i),
            {result, (op != 4'd7 && op != 4'd13), c_out, s_out, z_out, v_out},
            {VEC[i][11:4], (op != 4'd7 && op != 4'd13), VEC[i][3:0]});
      @(negedge clk);
    end

    // R7: compare and test withhold the write-back
    op = 4'd7; a = 8'h10; b = 8'h20; #2;
    check("R7 cmp we", {12'd0, result_we}, 13'd0);
    op = 4'd0; #2;
    check("R7 add we", {12'd0, result_we}, 13'd1);

    // R9: load with enable (ADD 7F+01 -> C S Z V = 0101)
    @(negedge clk);
    op = 4'd0; a = 8'h7F; b = 8'h01; flag_we = 1'b1;
    @(negedge clk);
    check("R9 load", {9'd0, flag_c, flag_s, flag_z, flag_v}, 13'b0101);

    // R9: hold while the enable is low, despite new flags
    flag_we = 1'b0; a = 8'hFF; b = 8'h01;
    repeat (2) @(negedge clk);
    check("R9 hold", {9'd0, flag_c, flag_s, flag_z, flag_v}, 13'b0101);

    // R9: compare loads flags (CMP 42,42 -> 1010)
    op = 4'd7; a = 8'h42; b = 8'h42; flag_we = 1'b1;
    @(negedge clk);
    check("R9 cmp load", {9'd0, flag_c, flag_s, flag_z, flag_v}, 13'b1010);
    flag_we = 1'b0;

    // R10: asynchronous reset clears the register again
    rst_n = 1'b0; #2;
    check("R10 reclear", {9'd0, flag_c, flag_s, flag_z, flag_v}, 13'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    summary();
  end

endmodule